// File: doc/BRIEF.md
# Host Serial Port Selector with One-Time Lock

This block decides which of the two host serial interfaces, I2C or SPI, serves the host once the device is in its normal operating mode. After a hard reset or a loss of supply, I2C is active. The host moves the device to SPI by driving the active-low slave-select pin from high to low three times. Either choice can then be frozen by a write to the second configuration register. The rule for that write depends on which port is active. When I2C is active, the port is locked only if the written data has its lock bit set. When SPI is active, any write to that register locks the port.

Once the port is locked, the choice stays until the reset pin is pulled low or the supply drops. Changes of operating mode do not affect it. The serial protocol engines read the port-select output and are not part of this block.

Top module: `host_port_select`

## Requirements
- R1: After the reset pin is released with the supply good, `port_spi` is 0 (I2C) and `port_locked` is 0.
- R2: While `normal_mode` is 1 and the port is unlocked, the third high-to-low transition of `sel_n` sets `port_spi` to 1. One or two transitions leave it at 0.
- R3: `sel_n` transitions that occur while `normal_mode` is 0 are not counted toward the three.
- R4: While I2C is active, a `cfg_wr` in normal mode with `cfg_wdata` bit 1 equal to 1 sets `port_locked`. The same write with bit 1 equal to 0 leaves the port unlocked. In both cases `port_spi` stays 0.
- R5: After I2C is locked, any number of `sel_n` transitions leave `port_spi` at 0.
- R6: While SPI is active, any `cfg_wr` in normal mode sets `port_locked`, whatever the data.
- R7: A locked port keeps both `port_locked` and `port_spi` unchanged across `normal_mode` changes and across later `cfg_wr` writes. SPI never returns to I2C without a hard reset.
- R8: Dropping `supply_ok` low returns the port to I2C, clears the lock and discards any partly counted transitions.
- R9: Pulling `rst_pin_n` low returns the port to I2C, clears the lock and discards any partly counted transitions.
- R10: A `cfg_wr` while `normal_mode` is 0 has no effect on the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Active-low hard reset pin, asynchronous |
| supply_ok | input | 1 | Supply-good indication; 0 acts as a reset |
| normal_mode | input | 1 | 1 while the device is in its normal operating mode |
| sel_n | input | 1 | Slave-select pin, asynchronous, idle high |
| cfg_wr | input | 1 | One-cycle write strobe for configuration register 2 |
| cfg_wdata | input | CFG_W | Data written with `cfg_wr` (bit 1 is the I2C lock bit) |
| port_spi | output | 1 | 0 = I2C is the active port, 1 = SPI |
| port_locked | output | 1 | 1 once the port choice is frozen |

## Verification
The bench produces `sel_n` pulse trains of one, two, three and more transitions in normal mode. This tells the third-edge switch apart from an early or late one. It repeats those trains outside normal mode and after an I2C lock to show that the edges are then not counted. Configuration writes with bit 1 set and clear are issued both with I2C active and with SPI active. This separates the data-dependent lock rule from the unconditional one. Both reset paths are applied after partial pulse trains, which shows that the count restarts. A seeded random mix of pulses, writes, mode changes and occasional resets is then checked against a reference model after every operation.

// File: rtl/hps_pkg.sv
package hps_pkg;
   typedef enum logic {
      HOST_I2C = 1'b0,
      HOST_SPI = 1'b1
   } host_port_e;

   typedef struct packed {
      host_port_e port;
      logic       locked;
   } host_sel_t;

   localparam host_sel_t HOST_SEL_RESET = '{port: HOST_I2C, locked: 1'b0};
endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hps_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hps_edge_count.sv
module hps_edge_count #(
   parameter int   TARGET      = 3,
   parameter bit   COUNT_FALL  = 1'b1,
   parameter logic IDLE        = 1'b1,
   localparam int  CNT_W       = (TARGET < 2) ? 1 : $clog2(TARGET + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic hit
);
   if (TARGET < 1) begin : g_bad_target
      $error("hps_edge_count: TARGET must be at least 1");
   end

   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TARGET);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TARGET - 1);

   logic             din_q;
   logic             edge_seen;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) din_q <= IDLE;
      else        din_q <= din;
   end

   if (COUNT_FALL) begin : g_fall
      assign edge_seen = din_q & ~din;
   end else begin : g_rise
      assign edge_seen = ~din_q & din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cnt <= '0;
      else if (en && edge_seen && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   assign hit = en & edge_seen & (cnt == CNT_LAST);

   // R3
   gated_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt));

   // R2
   saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/hps_lock_ctrl.sv
module hps_lock_ctrl
   import hps_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      normal_mode,
   input  logic      cfg_wr,
   input  logic      lock_bit,
   input  logic      hit,
   output host_sel_t sel
);
   logic is_spi;
   logic lock_req;

   assign is_spi   = (sel.port == HOST_SPI);
   assign lock_req = normal_mode & cfg_wr & (is_spi | lock_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= HOST_SEL_RESET;
      end else if (!sel.locked) begin
         if (lock_req)  sel.locked <= 1'b1;
         else if (hit)  sel.port   <= HOST_SPI;
      end
   end

   // R7
   sticky_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel.locked |=> sel.locked);

   // R5
   frozen_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel.locked |=> $stable(is_spi));

   // R7
   no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_spi |=> is_spi);

   // R2
   hit_only_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> !$rose(is_spi));

   // R10
   idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!normal_mode && !sel.locked) |=> !sel.locked);

   // R6
   spi_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (normal_mode && cfg_wr && is_spi) |=> sel.locked);
endmodule

// File: rtl/host_port_select.sv
module host_port_select
   import hps_pkg::*;
#(
   parameter int CFG_W       = 16,
   parameter int LOCK_BIT    = 1,
   parameter int EDGE_TARGET = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_pin_n,
   input  logic             supply_ok,
   input  logic             normal_mode,
   input  logic             sel_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             port_spi,
   output logic             port_locked
);
   if (LOCK_BIT < 0 || LOCK_BIT >= CFG_W) begin : g_bad_lock_bit
      $error("host_port_select: LOCK_BIT outside cfg_wdata");
   end

   localparam logic SEL_IDLE = 1'b1;

   logic      rst_n;
   logic      sel_sync;
   logic      edge_hit;
   logic      count_en;
   host_sel_t sel_state;
   logic      unused_cfg_bits;

   assign rst_n           = rst_pin_n & supply_ok;
   assign unused_cfg_bits = ^cfg_wdata;

   hps_sync #(
      .STAGES (SYNC_STAGES),
      .IDLE   (SEL_IDLE)
   ) u_sel_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sel_n),
      .q     (sel_sync)
   );

   assign count_en = normal_mode & ~sel_state.locked;

   hps_edge_count #(
      .TARGET     (EDGE_TARGET),
      .COUNT_FALL (1'b1),
      .IDLE       (SEL_IDLE)
   ) u_edge_count (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (count_en),
      .din   (sel_sync),
      .hit   (edge_hit)
   );

   hps_lock_ctrl u_lock_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .normal_mode (normal_mode),
      .cfg_wr      (cfg_wr),
      .lock_bit    (cfg_wdata[LOCK_BIT]),
      .hit         (edge_hit),
      .sel         (sel_state)
   );

   assign port_spi    = (sel_state.port == HOST_SPI);
   assign port_locked = sel_state.locked;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> (!port_spi && !port_locked));
endmodule

// File: tb/host_port_select_tb.sv
module host_port_select_tb;
   logic        clk = 1'b0;
   logic        rst_pin_n = 1'b0;
   logic        supply_ok = 1'b1;
   logic        normal_mode = 1'b0;
   logic        sel_n = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        port_spi;
   logic        port_locked;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // model state: {spi, locked, cnt[1:0]}
   logic [3:0] m = 4'b0;

   always #2.5 clk = ~clk;

   host_port_select u_dut (
      .clk         (clk),
      .rst_pin_n   (rst_pin_n),
      .supply_ok   (supply_ok),
      .normal_mode (normal_mode),
      .sel_n       (sel_n),
      .cfg_wr      (cfg_wr),
      .cfg_wdata   (cfg_wdata),
      .port_spi    (port_spi),
      .port_locked (port_locked)
   );

   function automatic logic [3:0] model_edge(input logic [3:0] s, input logic norm);
      logic [3:0] r = s;
      if (norm && !s[2]) begin
         if (s[1:0] == 2'd2) r[3] = 1'b1;
         if (s[1:0] != 2'd3) r[1:0] = s[1:0] + 2'd1;
      end
      return r;
   endfunction

   function automatic logic [3:0] model_write(input logic [3:0] s, input logic norm,
                                              input logic [15:0] d);
      logic [3:0] r = s;
      if (norm && !s[2] && (s[3] || d[1])) r[2] = 1'b1;
      return r;
   endfunction

   task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: {spi,locked} got=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic check_state(input string req);
      check(req, {port_spi, port_locked}, m[3:2]);
   endtask

   task automatic pulse_sel();
      @(negedge clk) sel_n = 1'b0;
      repeat (5) @(negedge clk);
      sel_n = 1'b1;
      repeat (5) @(negedge clk);
      m = model_edge(m, normal_mode);
   endtask

   task automatic cfg_write(input logic [15:0] d);
      @(negedge clk);
      cfg_wr    = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr    = 1'b0;
      m = model_write(m, normal_mode, d);
      repeat (2) @(negedge clk);
   endtask

   task automatic set_mode(input logic v);
      @(negedge clk) normal_mode = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic hard_reset(input bit use_supply);
      @(negedge clk);
      if (use_supply) supply_ok = 1'b0;
      else            rst_pin_n = 1'b0;
      repeat (3) @(negedge clk);
      supply_ok = 1'b1;
      rst_pin_n = 1'b1;
      m = 4'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(5ns * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (4) @(negedge clk);
      rst_pin_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", {port_spi, port_locked}, 2'b00);

      // R3: edges outside normal mode do not count
      pulse_sel(); pulse_sel(); pulse_sel();
      check("R3", {port_spi, port_locked}, 2'b00);
      set_mode(1'b1);
      pulse_sel(); pulse_sel();
      check("R2", {port_spi, port_locked}, 2'b00);
      pulse_sel();
      check("R2", {port_spi, port_locked}, 2'b10);
      pulse_sel();
      check_state("R2");

      // R6: SPI lock with any data
      cfg_write(16'h0000);
      check("R6", {port_spi, port_locked}, 2'b11);
      set_mode(1'b0); set_mode(1'b1);
      cfg_write(16'hFFFF);
      check("R7", {port_spi, port_locked}, 2'b11);

      // R9: partial count discarded by reset pin
      hard_reset(1'b0);
      check("R9", {port_spi, port_locked}, 2'b00);
      pulse_sel(); pulse_sel();
      hard_reset(1'b0);
      pulse_sel(); pulse_sel();
      check("R9", {port_spi, port_locked}, 2'b00);
      pulse_sel();
      check("R9", {port_spi, port_locked}, 2'b10);

      // R8: supply loss
      hard_reset(1'b1);
      check("R8", {port_spi, port_locked}, 2'b00);
      pulse_sel(); pulse_sel();
      hard_reset(1'b1);
      pulse_sel(); pulse_sel();
      check("R8", {port_spi, port_locked}, 2'b00);

      // R4: I2C lock needs bit 1
      cfg_write(16'hFFFD);
      check("R4", {port_spi, port_locked}, 2'b00);
      set_mode(1'b0);
      cfg_write(16'h0002);
      check("R10", {port_spi, port_locked}, 2'b00);
      set_mode(1'b1);
      cfg_write(16'h0002);
      check("R4", {port_spi, port_locked}, 2'b01);
      pulse_sel(); pulse_sel(); pulse_sel(); pulse_sel();
      check("R5", {port_spi, port_locked}, 2'b01);
      set_mode(1'b0); set_mode(1'b1);
      check("R7", {port_spi, port_locked}, 2'b01);

      hard_reset(1'b0);
      for (int i = 0; i < 300; i++) begin
         int op = $urandom_range(0, 99);
         if (op < 50)      pulse_sel();
         else if (op < 70) cfg_write(16'($urandom));
         else if (op < 90) set_mode(~normal_mode);
         else if (op < 95) hard_reset(1'b0);
         else              hard_reset(1'b1);
         check_state("R7");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule